// File: doc/BRIEF.md
# Dual Channel Console Port Registers

This block is the register face of a two-channel serial console, one channel for the main console and one for an auxiliary port. A host reaches it over a byte-wide bus with fixed offsets. Each channel has a status register, a command register that takes writes and discards them, and a holding register. Writing a holding register sends the byte out on that channel's transmit stream. Reading it takes the oldest received byte from a small receive FIFO. Baud rate generation and line framing sit elsewhere. This block only moves bytes between the bus and the two byte streams.

A shared register holds four interrupt enables. The enables decide when a single interrupt line is raised. A receive event on an enabled channel raises it. A free-running tick raises it whenever either transmit enable is set. Only a status read on channel A lowers it.

Stream rules: each receive input is a valid/ready byte stream whose ready is held high. A byte is taken on every cycle its valid is high. A byte that meets a full FIFO is thrown away and recorded in a sticky flag. The transmit outputs are valid-only. A byte is presented for exactly one cycle and the consumer must take it, because the transmitter always reports ready.

Top module: `dual_console_regs`

## Requirements
- R1: Status registers sit at 0x0C (channel A) and 0x4C (channel B). Bit 0 is 1 while that channel's receive FIFO holds a byte, and bit 2 always reads 1.
- R2: A read of a holding register (0x1C for A, 0x5C for B) returns that channel's received bytes oldest first and removes each one. Every read returns its data on `bus_rdata` with `bus_rvalid` high in the cycle after `bus_rd`.
- R3: A read of an empty holding register returns 0x00 and leaves the FIFO intact. The next byte received is the one that is read back next.
- R4: Each receive FIFO holds 16 bytes. A byte that arrives while the FIFO is full is dropped, and status bit 4 of that channel becomes 1 and stays 1 until reset. The receive ready outputs are always 1.
- R5: A write to a holding register puts the low byte of `bus_wdata` on that channel's transmit data, with its valid high for one cycle, in the cycle after the write. The other channel does not transmit.
- R6: The interrupt register at 0x2C is read/write over all 8 bits. Bit 0 enables channel A transmit, bit 1 channel A receive, bit 4 channel B transmit and bit 5 channel B receive.
- R7: Writes to the command registers (0x14 and 0x54) change nothing. Reads of those registers return 0x00.
- R8: A byte arriving on channel A while enable bit 1 is set, or on channel B while enable bit 5 is set, drives `irq` high from the next cycle. With the matching bit clear, `irq` stays low.
- R9: A read of channel A status drives `irq` low from the next cycle. A read of channel B status leaves it unchanged.
- R10: Every TICK_PERIOD cycles, if enable bit 0 or bit 4 is set, `irq` goes high. With both bits clear, the tick has no effect.
- R11: After reset the interrupt register reads 0x00, both FIFOs are empty, both overflow flags are clear, `irq` is low and no transmit valid is high.
- R12: If a raise event and a channel A status read fall in the same cycle, the raise wins and `irq` is high afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 8 | Register offset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after bus_rd |
| rxa_valid | input | 1 | Channel A received byte valid |
| rxa_ready | output | 1 | Channel A ready, always 1 |
| rxa_data | input | 8 | Channel A received byte |
| rxb_valid | input | 1 | Channel B received byte valid |
| rxb_ready | output | 1 | Channel B ready, always 1 |
| rxb_data | input | 8 | Channel B received byte |
| txa_valid | output | 1 | Channel A transmit byte valid (one-cycle pulse) |
| txa_data | output | 8 | Channel A transmit byte |
| txb_valid | output | 1 | Channel B transmit byte valid (one-cycle pulse) |
| txb_data | output | 8 | Channel B transmit byte |
| irq | output | 1 | Shared interrupt, active high |

## Verification
Every result arrives exactly one clock edge after the stimulus that causes it:
- read data and its valid follow the read strobe;
- a transmit pulse follows the holding-register write;
- `irq` rises after a receive or tick event and falls after a channel A status read.

Tick-driven raises come TICK_PERIOD cycles apart. The bench drives each stimulus for one cycle on a falling edge. Its scoreboard queues the expected read and transmit bytes at that moment and compares them on the next falling edge, one rising edge later. `irq` is sampled on that same falling edge. The tick spacing is checked as the time between two observed raises.

// File: rtl/console_pkg.sv
package console_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 8;
  localparam int CH_NUM = 2;

  // channel A offsets; channel B sits one stride above
  localparam logic [ADDR_W-1:0] OFF_STAT_A = 8'h0C;
  localparam logic [ADDR_W-1:0] OFF_CMD_A  = 8'h14;
  localparam logic [ADDR_W-1:0] OFF_HOLD_A = 8'h1C;
  localparam logic [ADDR_W-1:0] OFF_INT    = 8'h2C;
  localparam logic [ADDR_W-1:0] CH_STRIDE  = 8'h40;

  // status bits
  localparam int ST_RXAVAIL = 0;
  localparam int ST_TXRDY   = 2;
  localparam int ST_OVF     = 4;

  // interrupt enable bits
  localparam int EN_TXA = 0;
  localparam int EN_RXA = 1;
  localparam int EN_TXB = 4;
  localparam int EN_RXB = 5;

  function automatic logic [ADDR_W-1:0] ch_off(logic [ADDR_W-1:0] base, int ch);
    return base + ADDR_W'(ch) * CH_STRIDE;
  endfunction
endpackage

// File: rtl/cons_rx_fifo.sv
module cons_rx_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         ovf
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = PW + 1;

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          full, do_push, do_pop;

  assign full    = (cnt == CW'(DEPTH));
  assign empty   = (cnt == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rp];

  function automatic logic [PW-1:0] nxt(logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
      ovf <= 1'b0;
    end else begin
      if (do_push) wp <= nxt(wp);
      if (do_pop)  rp <= nxt(rp);
      cnt <= cnt + CW'(do_push) - CW'(do_pop);
      if (push && full) ovf <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end
endmodule

// File: rtl/cons_tick_gen.sv
module cons_tick_gen #(
  parameter int PERIOD = 1024
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;

  logic [CW-1:0] cnt;

  assign tick = (cnt == CW'(PERIOD - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (tick) cnt <= '0;
    else           cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/dual_console_regs.sv
module dual_console_regs
  import console_pkg::*;
#(
  parameter int FIFO_DEPTH  = 16,
  parameter int TICK_PERIOD = 1024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_rvalid,
  input  logic              rxa_valid,
  output logic              rxa_ready,
  input  logic [DATA_W-1:0] rxa_data,
  input  logic              rxb_valid,
  output logic              rxb_ready,
  input  logic [DATA_W-1:0] rxb_data,
  output logic              txa_valid,
  output logic [DATA_W-1:0] txa_data,
  output logic              txb_valid,
  output logic [DATA_W-1:0] txb_data,
  output logic              irq
);
  logic [CH_NUM-1:0] rx_v, pop, empty, ovf, tx_v;
  logic [DATA_W-1:0] rx_d   [CH_NUM];
  logic [DATA_W-1:0] head   [CH_NUM];
  logic [DATA_W-1:0] stat   [CH_NUM];
  logic [DATA_W-1:0] tx_d   [CH_NUM];
  logic [DATA_W-1:0] mask_q, rd_mux;
  logic              tick, irq_set, irq_clr;

  assign rx_v      = {rxb_valid, rxa_valid};
  assign rx_d[0]   = rxa_data;
  assign rx_d[1]   = rxb_data;
  assign rxa_ready = 1'b1;
  assign rxb_ready = 1'b1;
  assign txa_valid = tx_v[0];
  assign txb_valid = tx_v[1];
  assign txa_data  = tx_d[0];
  assign txb_data  = tx_d[1];

  cons_tick_gen #(.PERIOD(TICK_PERIOD)) u_tick (
    .clk (clk),
    .rst_n (rst_n),
    .tick (tick)
  );

  for (genvar c = 0; c < CH_NUM; c++) begin : g_ch
    assign pop[c] = bus_rd && (bus_addr == ch_off(OFF_HOLD_A, c));

    cons_rx_fifo #(.DEPTH(FIFO_DEPTH), .W(DATA_W)) u_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (rx_v[c]),
      .din   (rx_d[c]),
      .pop   (pop[c]),
      .dout  (head[c]),
      .empty (empty[c]),
      .ovf   (ovf[c])
    );

    always_comb begin
      stat[c]             = '0;
      stat[c][ST_RXAVAIL] = !empty[c];
      stat[c][ST_TXRDY]   = 1'b1;
      stat[c][ST_OVF]     = ovf[c];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        tx_v[c] <= 1'b0;
        tx_d[c] <= '0;
      end else begin
        tx_v[c] <= bus_wr && (bus_addr == ch_off(OFF_HOLD_A, c));
        if (bus_wr && (bus_addr == ch_off(OFF_HOLD_A, c))) tx_d[c] <= bus_wdata;
      end
    end
  end

  // read mux: command registers and unknown offsets read as zero
  always_comb begin
    rd_mux = '0;
    if (bus_addr == OFF_INT) rd_mux = mask_q;
    for (int c = 0; c < CH_NUM; c++) begin
      if (bus_addr == ch_off(OFF_STAT_A, c)) rd_mux = stat[c];
      if (bus_addr == ch_off(OFF_HOLD_A, c)) rd_mux = empty[c] ? '0 : head[c];
    end
  end

  assign irq_set = (rx_v[0] && mask_q[EN_RXA]) ||
                   (rx_v[1] && mask_q[EN_RXB]) ||
                   (tick && (mask_q[EN_TXA] || mask_q[EN_TXB]));
  assign irq_clr = bus_rd && (bus_addr == OFF_STAT_A);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q     <= '0;
      irq        <= 1'b0;
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      if (bus_wr && bus_addr == OFF_INT) mask_q <= bus_wdata;
      if (irq_set)      irq <= 1'b1;
      else if (irq_clr) irq <= 1'b0;
      bus_rvalid <= bus_rd;
      if (bus_rd) bus_rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/dual_console_regs_chk.sv
module dual_console_regs_chk
  import console_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              bus_rvalid,
  input logic              rxa_valid,
  input logic              rxa_ready,
  input logic              rxb_ready,
  input logic              txa_valid,
  input logic [DATA_W-1:0] txa_data,
  input logic              txb_valid,
  input logic              irq,
  input logic [DATA_W-1:0] mask_q
);
  p_txrdy_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == OFF_STAT_A) |=> bus_rdata[ST_TXRDY]);

  p_rvalid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |=> bus_rvalid);

  p_no_rvalid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> !bus_rvalid);

  p_rx_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rxa_ready && rxb_ready);

  p_tx_emit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == OFF_HOLD_A) |=> (txa_valid && txa_data == $past(bus_wdata)));

  p_tx_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_addr == OFF_HOLD_A + CH_STRIDE) |=> !txb_valid);

  p_int_rw_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == OFF_INT) |=> (mask_q == $past(bus_wdata)));

  p_cmd_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && (bus_addr == OFF_CMD_A || bus_addr == OFF_CMD_A + CH_STRIDE)) |=> (bus_rdata == '0));

  p_rx_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rxa_valid && mask_q[EN_RXA]) |=> irq);

  p_irq_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !(bus_rd && bus_addr == OFF_STAT_A)) |=> irq);
endmodule

bind dual_console_regs dual_console_regs_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_addr   (bus_addr),
  .bus_wr     (bus_wr),
  .bus_rd     (bus_rd),
  .bus_wdata  (bus_wdata),
  .bus_rdata  (bus_rdata),
  .bus_rvalid (bus_rvalid),
  .rxa_valid  (rxa_valid),
  .rxa_ready  (rxa_ready),
  .rxb_ready  (rxb_ready),
  .txa_valid  (txa_valid),
  .txa_data   (txa_data),
  .txb_valid  (txb_valid),
  .irq        (irq),
  .mask_q     (mask_q)
);

// File: tb/dual_console_regs_test.sv
module dual_console_regs_test;
  localparam int CLK_PERIOD = 10;
  localparam int TICK       = 40;
  localparam int WD_CYCLES  = 20000;

  localparam logic [7:0] A_STAT = 8'h0C, A_CMD = 8'h14, A_HOLD = 8'h1C, A_INT = 8'h2C;
  localparam logic [7:0] B_STAT = 8'h4C, B_CMD = 8'h54, B_HOLD = 8'h5C;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] bus_addr = '0, bus_wdata = '0, rxa_data = '0, rxb_data = '0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0, rxa_valid = 1'b0, rxb_valid = 1'b0;
  logic [7:0] bus_rdata, txa_data, txb_data;
  logic       bus_rvalid, rxa_ready, rxb_ready, txa_valid, txb_valid, irq;

  int checks = 0;
  int failures = 0;

  logic [7:0] exp_rd [$];
  string      exp_tag [$];
  logic [7:0] exp_txa [$];
  logic [7:0] exp_txb [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_console_regs #(.FIFO_DEPTH(16), .TICK_PERIOD(TICK)) uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .rxa_valid(rxa_valid), .rxa_ready(rxa_ready), .rxa_data(rxa_data),
    .rxb_valid(rxb_valid), .rxb_ready(rxb_ready), .rxb_data(rxb_data),
    .txa_valid(txa_valid), .txa_data(txa_data), .txb_valid(txb_valid),
    .txb_data(txb_data), .irq(irq)
  );

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // scoreboard monitors: read data and transmit bytes
  always @(negedge clk) begin
    if (rst_n && bus_rvalid) begin
      if (exp_rd.size() == 0) check(0, "R2 unexpected read data", bus_rdata, 0);
      else begin
        automatic logic [7:0] e = exp_rd.pop_front();
        automatic string t = exp_tag.pop_front();
        check(bus_rdata == e, t, bus_rdata, e);
      end
    end
    if (rst_n && txa_valid) begin
      if (exp_txa.size() == 0) check(0, "R5 unexpected txa", txa_data, 0);
      else begin
        automatic logic [7:0] e = exp_txa.pop_front();
        check(txa_data == e, "R5 txa byte", txa_data, e);
      end
    end
    if (rst_n && txb_valid) begin
      if (exp_txb.size() == 0) check(0, "R5 unexpected txb", txb_data, 0);
      else begin
        automatic logic [7:0] e = exp_txb.pop_front();
        check(txb_data == e, "R5 txb byte", txb_data, e);
      end
    end
  end

  task automatic host_write(logic [7:0] a, logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    if (a == A_HOLD) exp_txa.push_back(d);
    if (a == B_HOLD) exp_txb.push_back(d);
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic host_read(logic [7:0] a, logic [7:0] e, string tag);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    exp_rd.push_back(e); exp_tag.push_back(tag);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic rx_push(bit ch, logic [7:0] d);
    @(negedge clk);
    if (ch) begin rxb_valid = 1'b1; rxb_data = d; end
    else    begin rxa_valid = 1'b1; rxa_data = d; end
    @(negedge clk);
    rxa_valid = 1'b0; rxb_valid = 1'b0;
  endtask

  task automatic wait_irq(output realtime t);
    int n = 0;
    while (!irq && n < TICK + 4) begin
      @(negedge clk);
      n++;
    end
    check(irq == 1'b1, "R10 tick raise", irq, 1);
    t = $realtime;
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    check(0, "watchdog expired", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    realtime t1, t2;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11 reset state
    check(irq == 1'b0, "R11 irq after reset", irq, 0);
    check(txa_valid == 1'b0 && txb_valid == 1'b0, "R11 tx idle", {txb_valid, txa_valid}, 0);
    check(rxa_ready && rxb_ready, "R4 ready high", {rxb_ready, rxa_ready}, 3);
    host_read(A_STAT, 8'h04, "R11 status A");
    host_read(B_STAT, 8'h04, "R11 status B");
    host_read(A_INT, 8'h00, "R11 enables");
    host_read(A_HOLD, 8'h00, "R3 empty hold A");

    // R5 transmit
    host_write(A_HOLD, 8'h41);
    host_write(B_HOLD, 8'h42);
    host_write(A_HOLD, 8'hC3);

    // R6 enable register read/write
    host_write(A_INT, 8'h5A);
    host_read(A_INT, 8'h5A, "R6 readback 5A");
    host_write(A_INT, 8'hA5);
    host_read(A_INT, 8'hA5, "R6 readback A5");
    host_write(A_INT, 8'h00);
    host_read(A_STAT, 8'h04, "R1 status A");
    check(irq == 1'b0, "R9 cleared", irq, 0);

    // R7 command registers
    host_write(A_CMD, 8'hFF);
    host_write(B_CMD, 8'hFF);
    host_read(A_INT, 8'h00, "R7 enables unchanged");
    host_read(A_STAT, 8'h04, "R7 status A unchanged");
    host_read(B_STAT, 8'h04, "R7 status B unchanged");
    host_read(A_CMD, 8'h00, "R7 cmd A reads 0");
    host_read(B_CMD, 8'h00, "R7 cmd B reads 0");
    check(irq == 1'b0, "R7 irq unchanged", irq, 0);

    // R1/R2 receive ordering
    rx_push(0, 8'h11); rx_push(0, 8'h22); rx_push(0, 8'h33);
    rx_push(1, 8'h99);
    host_read(A_STAT, 8'h05, "R1 status A avail");
    host_read(B_STAT, 8'h05, "R1 status B avail");
    host_read(A_HOLD, 8'h11, "R2 A first");
    host_read(A_HOLD, 8'h22, "R2 A second");
    host_read(B_HOLD, 8'h99, "R2 B first");
    host_read(B_STAT, 8'h04, "R1 status B drained");
    host_read(A_HOLD, 8'h33, "R2 A third");
    host_read(A_STAT, 8'h04, "R1 status A drained");

    // R8/R9 receive interrupts
    host_write(A_INT, 8'h02);
    rx_push(1, 8'h77);
    check(irq == 1'b0, "R8 B without enable", irq, 0);
    rx_push(0, 8'h55);
    check(irq == 1'b1, "R8 A with enable", irq, 1);
    host_read(B_STAT, 8'h05, "R9 status B read");
    check(irq == 1'b1, "R9 status B keeps irq", irq, 1);
    host_read(A_STAT, 8'h05, "R9 status A read");
    check(irq == 1'b0, "R9 status A clears irq", irq, 0);
    host_write(A_INT, 8'h20);
    rx_push(1, 8'h66);
    check(irq == 1'b1, "R8 B with enable", irq, 1);
    host_read(A_STAT, 8'h05, "R9 status A read 2");
    check(irq == 1'b0, "R9 clear 2", irq, 0);
    host_read(A_HOLD, 8'h55, "R2 A 55");
    host_read(B_HOLD, 8'h77, "R2 B 77");
    host_read(B_HOLD, 8'h66, "R2 B 66");

    // R12 raise and clear in the same cycle
    @(negedge clk);
    rxb_valid = 1'b1; rxb_data = 8'h44;
    bus_rd = 1'b1; bus_addr = A_STAT;
    exp_rd.push_back(8'h04); exp_tag.push_back("R12 status A");
    @(negedge clk);
    rxb_valid = 1'b0; bus_rd = 1'b0;
    check(irq == 1'b1, "R12 raise wins", irq, 1);
    host_read(A_STAT, 8'h04, "R12 status A again");
    check(irq == 1'b0, "R12 later clear", irq, 0);
    host_read(B_HOLD, 8'h44, "R12 B byte");

    // R3 empty read does not underflow
    host_read(B_HOLD, 8'h00, "R3 empty hold B");
    rx_push(1, 8'h12);
    host_read(B_HOLD, 8'h12, "R3 next byte after empty read");
    host_read(B_STAT, 8'h04, "R3 status B empty");

    // R4 overflow
    host_write(A_INT, 8'h00);
    for (int i = 0; i < 17; i++) rx_push(0, 8'(8'h80 + i));
    host_read(A_STAT, 8'h15, "R4 full with overflow");
    for (int i = 0; i < 16; i++) host_read(A_HOLD, 8'(8'h80 + i), "R4 kept bytes");
    host_read(A_HOLD, 8'h00, "R4 dropped byte absent");
    host_read(A_STAT, 8'h14, "R4 overflow sticky");
    check(irq == 1'b0, "R4 irq low", irq, 0);

    // R10 periodic transmit interrupt
    host_write(A_INT, 8'h10);
    wait_irq(t1);
    host_read(A_STAT, 8'h14, "R10 clear read");
    check(irq == 1'b0, "R10 cleared", irq, 0);
    wait_irq(t2);
    check((t2 - t1) == realtime'(TICK * CLK_PERIOD), "R10 tick spacing",
          int'((t2 - t1) / CLK_PERIOD), TICK);
    host_write(A_INT, 8'h00);
    host_read(A_STAT, 8'h14, "R10 final clear");
    begin
      bit seen = 1'b0;
      for (int i = 0; i < 2 * TICK; i++) begin
        @(negedge clk);
        if (irq) seen = 1'b1;
      end
      check(!seen, "R10 no raise with enables clear", seen, 0);
    end

    repeat (3) @(negedge clk);
    check(exp_rd.size() == 0, "R2 all reads returned", exp_rd.size(), 0);
    check(exp_txa.size() == 0 && exp_txb.size() == 0, "R5 all bytes sent",
          exp_txa.size() + exp_txb.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule